// File: doc/BRIEF.md
# PCI Bus Request Keeper

This block owns the active-low bus request line of a single bus-master DMA engine on a 33 MHz PCI bus. The DMA side raises a pending level whenever it has an access to make; the block asserts the request, watches the arbiter's active-low grant and the bus-idle indication, and hands the DMA side a one-clock "go" strobe when it may begin. The DMA side answers with a one-clock done pulse when its transfer ends.

By default the request is given back as soon as a transfer completes with nothing further pending. With the keep mode on, the request is left asserted across back-to-back accesses so the engine does not re-arbitrate between them. A two-bit drop field can bound that: zero keeps the request indefinitely; values one to three force it off after that many 32-clock units of unbroken assertion, followed by a short mandatory gap before it may be raised again.

There is no data stream at this edge, so no valid/ready pair: all pins are plain control levels or single-cycle pulses, and the DMA side is expected not to pulse done unless a transfer it was started on is in flight.

Top module: `pci_req_keeper`

## Requirements
- R1: While reset is low, bus_req_n is 1 and dma_go is 0.
- R2: With bus_req_n high, no forced-release gap running and dma_pend high at a clock edge, bus_req_n is 0 after that edge.
- R3: dma_go is 1 for exactly one clock, following an edge at which bus_req_n was 0, bus_gnt_n was 0, bus_idle was 1, dma_pend was 1 and no transfer was in flight.
- R4: Once dma_go has pulsed, no further dma_go is issued until a dma_done pulse has been sampled.
- R5: With keep_en low, a dma_done sampled while dma_pend is low makes bus_req_n go to 1 after that edge; if dma_pend is high at that edge the request stays asserted. With keep_en low, no transfer in flight and dma_pend low, the request is also dropped.
- R6: With keep_en high, completing a transfer with dma_pend low leaves bus_req_n at 0.
- R7: With keep_en high and drop_sel = 00, bus_req_n stays 0 for as long as those settings hold, with no timer release.
- R8: With keep_en high and drop_sel = k (1, 2 or 3), bus_req_n stays 0 for exactly k x 32 consecutive clocks and is then forced to 1.
- R9: After a forced release bus_req_n stays 1 for at least two clocks; with dma_pend held high it returns to 0 exactly three clocks after it rose.
- R10: The assertion-length count restarts from zero whenever the request is deasserted and does not advance while keep_en is low: a request held with keep_en low and then switched to keep_en high, drop_sel = 01, is released exactly 32 clocks after keep_en rose.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pci_clk | input | 1 | 33 MHz bus clock; everything samples on its rising edge |
| pci_rst_n | input | 1 | Active-low bus reset, asynchronous assertion |
| dma_pend | input | 1 | DMA side has an access waiting |
| dma_done | input | 1 | One-clock pulse: the started transfer has ended |
| bus_gnt_n | input | 1 | Arbiter grant, active low |
| bus_idle | input | 1 | Bus sampled idle (no frame, no initiator ready) |
| keep_en | input | 1 | Keep the request asserted between accesses |
| drop_sel | input | 2 | Forced-release length in 32-clock units; 00 never |
| bus_req_n | output | 1 | Bus request, active low, registered |
| dma_go | output | 1 | One-clock strobe: bus owned, transfer may start |

## Verification
The bench builds the block with a 32-clock unit and a two-clock release gap, the values the bus uses, so every drop_sel setting (32, 64 and 96 clocks) is reached in a few hundred cycles and the exact lengths of the held request and of the gap can be counted. Directed sequences cover the keep-off drop with and without further pending work, the indefinite hold, each timer length, the gap, and a hold that starts mid-transfer to show the count only begins when keep_en rises. A long random run with grant, idle, pending and mode changes is compared every cycle against a bench model.

// File: rtl/pci_req_pkg.sv
package pci_req_pkg;
  // width of the forced-release field
  localparam int SEL_W = 2;
  typedef logic [SEL_W-1:0] drop_sel_t;
endpackage

// File: rtl/req_run_timer.sv
module req_run_timer
  import pci_req_pkg::*;
#(
  parameter int UNIT = 32
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_on,
  input  logic      keep_en,
  input  drop_sel_t drop_sel,
  output logic      expire
);
  localparam int MAXC  = UNIT * ((1 << SEL_W) - 1);
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim = CNT_W'(drop_sel) * CNT_W'(UNIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!req_on || !keep_en) begin
      cnt <= '0;
    end else if (cnt != CNT_W'(MAXC)) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_comb begin
    expire = req_on && keep_en && (drop_sel != '0) && (cnt >= lim - CNT_W'(1));
  end

  p_cnt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !keep_en |=> (cnt == '0));
  p_cnt_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_on |=> (cnt == '0));
endmodule

// File: rtl/req_gap.sv
module req_gap #(
  parameter int GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic gap_on
);
  localparam int GW = $clog2(GAP + 2);

  logic [GW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (fire) begin
      left <= GW'(GAP);
    end else if (left != '0) begin
      left <= left - GW'(1);
    end
  end

  assign gap_on = (left != '0);

  p_gap_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((GAP == 0) || gap_on));
endmodule

// File: rtl/req_start_gen.sv
module req_start_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic req_on,
  input  logic gnt_n,
  input  logic bus_idle,
  input  logic pend,
  input  logic done,
  output logic go,
  output logic busy
);
  logic launch;

  assign launch = req_on && !gnt_n && bus_idle && pend && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go   <= 1'b0;
      busy <= 1'b0;
    end else begin
      go <= launch;
      if (launch) begin
        busy <= 1'b1;
      end else if (done) begin
        busy <= 1'b0;
      end
    end
  end

  p_go_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);
  p_go_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> !go);
endmodule

// File: rtl/pci_req_keeper.sv
module pci_req_keeper
  import pci_req_pkg::*;
#(
  parameter int UNIT = 32,
  parameter int GAP  = 2
) (
  input  logic             pci_clk,
  input  logic             pci_rst_n,
  input  logic             dma_pend,
  input  logic             dma_done,
  input  logic             bus_gnt_n,
  input  logic             bus_idle,
  input  logic             keep_en,
  input  logic [SEL_W-1:0] drop_sel,
  output logic             bus_req_n,
  output logic             dma_go
);
  logic req_q;
  logic busy;
  logic expire;
  logic gap_on;
  logic drop_now;
  logic raise_now;

  req_run_timer #(.UNIT(UNIT)) u_tmr (
    .clk      (pci_clk),
    .rst_n    (pci_rst_n),
    .req_on   (req_q),
    .keep_en  (keep_en),
    .drop_sel (drop_sel),
    .expire   (expire)
  );

  req_gap #(.GAP(GAP)) u_gap (
    .clk    (pci_clk),
    .rst_n  (pci_rst_n),
    .fire   (expire),
    .gap_on (gap_on)
  );

  req_start_gen u_go (
    .clk      (pci_clk),
    .rst_n    (pci_rst_n),
    .req_on   (req_q),
    .gnt_n    (bus_gnt_n),
    .bus_idle (bus_idle),
    .pend     (dma_pend),
    .done     (dma_done),
    .go       (dma_go),
    .busy     (busy)
  );

  // give the bus back when nothing is left to do and keep mode is off
  assign drop_now  = req_q && !keep_en && !dma_pend && (!busy || dma_done);
  assign raise_now = !req_q && !gap_on && dma_pend;

  always_ff @(posedge pci_clk or negedge pci_rst_n) begin
    if (!pci_rst_n) begin
      req_q <= 1'b0;
    end else if (expire || drop_now) begin
      req_q <= 1'b0;
    end else if (raise_now) begin
      req_q <= 1'b1;
    end
  end

  assign bus_req_n = !req_q;

  p_drop_after_done_r5: assert property (@(posedge pci_clk) disable iff (!pci_rst_n)
    (!bus_req_n && !keep_en && !dma_pend && busy && dma_done) |=> bus_req_n);
  p_keep_held_r6: assert property (@(posedge pci_clk) disable iff (!pci_rst_n)
    (!bus_req_n && keep_en && !expire) |=> !bus_req_n);
  p_no_timer_r7: assert property (@(posedge pci_clk) disable iff (!pci_rst_n)
    (!bus_req_n && keep_en && (drop_sel == '0)) |=> !bus_req_n);
  p_gap_hold_r9: assert property (@(posedge pci_clk) disable iff (!pci_rst_n)
    expire |=> (bus_req_n ##1 bus_req_n));
  p_go_cond_r3: assert property (@(posedge pci_clk) disable iff (!pci_rst_n)
    dma_go |-> $past(!bus_gnt_n && bus_idle && dma_pend && !bus_req_n));
endmodule

// File: tb/sim_pci_req_keeper.sv
module sim_pci_req_keeper;
  localparam int PER  = 30;
  localparam int UNIT = 32;
  localparam int GAP  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pend = 1'b0;
  logic       done = 1'b0;
  logic       gnt_n = 1'b1;
  logic       idle = 1'b1;
  logic       keep = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       req_n;
  logic       go;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    cmp_en = 1'b0;
  string cur_tag = "R1";

  // bench reference state
  bit m_req, m_busy, m_go;
  int m_run, m_cool;

  always #(PER/2) clk = ~clk;

  pci_req_keeper #(.UNIT(UNIT), .GAP(GAP)) u0 (
    .pci_clk   (clk),
    .pci_rst_n (rst_n),
    .dma_pend  (pend),
    .dma_done  (done),
    .bus_gnt_n (gnt_n),
    .bus_idle  (idle),
    .keep_en   (keep),
    .drop_sel  (sel),
    .bus_req_n (req_n),
    .dma_go    (go)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit fn_forced(bit r, bit k, logic [1:0] s, int run);
    return r && k && (s != 2'b00) && (run + 1 >= int'(s) * UNIT);
  endfunction

  // reference model, stepped on each rising edge from the settled inputs
  always @(posedge clk) begin
    bit f, lau, dn;
    if (!rst_n) begin
      m_req = 0; m_busy = 0; m_go = 0; m_run = 0; m_cool = 0;
    end else begin
      f   = fn_forced(m_req, keep, sel, m_run);
      lau = m_req && !gnt_n && idle && pend && !m_busy;
      dn  = m_req && !keep && !pend && (!m_busy || done);
      m_run  = (m_req && keep) ? m_run + 1 : 0;
      m_go   = lau;
      m_busy = lau ? 1'b1 : (done ? 1'b0 : m_busy);
      if (f || dn) m_req = 0;
      else if (!m_req && m_cool == 0 && pend) m_req = 1;
      if (f) m_cool = GAP;
      else if (m_cool > 0) m_cool = m_cool - 1;
      if (!m_req) m_run = 0;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && cmp_en) begin
      chk(req_n == !m_req, {cur_tag, " req model"}, int'(req_n), int'(!m_req));
      chk(go == m_go, {cur_tag, " go model"}, int'(go), int'(m_go));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wait_go();
    for (int i = 0; i < 20; i++) begin
      if (go) return;
      @(negedge clk);
    end
    chk(1'b0, {cur_tag, " go never seen"}, 0, 1);
  endtask

  task automatic run_len(input bit lvl, output int n);
    n = 0;
    while (req_n == lvl && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    bit ok_hold;
    bit inflight;
    int dl;
    void'($urandom(32'd4711));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(req_n == 1'b1, "R1 req in reset", int'(req_n), 1);
    chk(go == 1'b0, "R1 go in reset", int'(go), 0);
    pend = 1'b1;
    @(negedge clk);
    chk(req_n == 1'b1, "R1 req ignores pend in reset", int'(req_n), 1);
    pend = 1'b0;
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);

    // R2, R3, R4: raise, grant, single go
    cur_tag = "R2";
    pend = 1'b1;
    chk(req_n == 1'b1, "R2 before edge", int'(req_n), 1);
    @(negedge clk);
    chk(req_n == 1'b0, "R2 raised", int'(req_n), 0);
    cur_tag = "R3";
    gnt_n = 1'b0;
    @(negedge clk);
    chk(go == 1'b1, "R3 go pulse", int'(go), 1);
    @(negedge clk);
    chk(go == 1'b0, "R3 go one clock", int'(go), 0);
    cur_tag = "R4";
    n = 0;
    repeat (4) begin
      @(negedge clk);
      if (go) n++;
    end
    chk(n == 0, "R4 no go while in flight", n, 0);

    // R5: done with more pending keeps request, then done with none drops it
    cur_tag = "R5";
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk(req_n == 1'b0, "R5 kept with pend", int'(req_n), 0);
    wait_go();
    @(negedge clk);
    pend = 1'b0; done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk(req_n == 1'b1, "R5 dropped after done", int'(req_n), 1);
    @(negedge clk);

    // R6, R7: keep mode with no timer
    cur_tag = "R6";
    keep = 1'b1; sel = 2'b00; pend = 1'b1;
    @(negedge clk);
    wait_go();
    @(negedge clk);
    pend = 1'b0; done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk(req_n == 1'b0, "R6 held after done", int'(req_n), 0);
    cur_tag = "R7";
    ok_hold = 1'b1;
    repeat (200) begin
      @(negedge clk);
      if (req_n) ok_hold = 1'b0;
    end
    chk(ok_hold, "R7 never released", int'(ok_hold), 1);
    keep = 1'b0;
    @(negedge clk);
    chk(req_n == 1'b1, "R5 drop when keep cleared idle", int'(req_n), 1);
    gnt_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8, R9: each timer length and the gap after it
    for (int k = 1; k <= 3; k++) begin
      cur_tag = "R8";
      keep = 1'b1; sel = 2'(k); pend = 1'b1;
      @(negedge clk);
      run_len(1'b0, n);
      chk(n == k * UNIT, "R8 held length", n, k * UNIT);
      cur_tag = "R9";
      run_len(1'b1, n);
      chk(n >= 2, "R9 gap at least two", n, 2);
      chk(n == GAP + 1, "R9 gap exact", n, GAP + 1);
      keep = 1'b0; pend = 1'b0;
      repeat (3) @(negedge clk);
    end

    // R10: count starts when keep rises mid-transfer and restarts after drop
    cur_tag = "R10";
    sel = 2'b01; pend = 1'b1; gnt_n = 1'b0;
    @(negedge clk);
    wait_go();
    repeat (50) @(negedge clk);
    chk(req_n == 1'b0, "R10 held with keep off", int'(req_n), 0);
    keep = 1'b1;
    run_len(1'b0, n);
    chk(n == UNIT, "R10 count from keep rise", n, UNIT);
    run_len(1'b1, n);
    run_len(1'b0, n);
    chk(n == UNIT, "R10 count restarts after drop", n, UNIT);
    keep = 1'b0; pend = 1'b0; done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    repeat (4) @(negedge clk);
    chk(req_n == 1'b1, "R5 idle after cleanup", int'(req_n), 1);

    // random phase, model compared every cycle
    cur_tag = "R3";
    inflight = 1'b0; dl = 0;
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      done = 1'b0;
      if (inflight) begin
        if (dl == 0) begin done = 1'b1; inflight = 1'b0; end
        else dl--;
      end
      if (go) begin inflight = 1'b1; dl = $urandom_range(0, 4); end
      pend  = ($urandom_range(0, 3) != 0);
      gnt_n = ($urandom_range(0, 2) == 0);
      idle  = ($urandom_range(0, 4) != 0);
      if (c % 97 == 0) begin
        keep = $urandom_range(0, 1);
        sel  = 2'($urandom_range(0, 3));
      end
    end
    done = 1'b0;
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule